// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing part of an instruction into a usable result. It takes a four-bit mode code, an address field, a register selector, the current program counter and an auto-index flag. In one pass it produces either the effective address of the operand or, for the modes that need no memory, the operand value itself. A single-cycle `done` strobe marks the result. Register contents come from an external register file. The block reads them through a combinational read port and can write one back through a write port. Pointer words come from an external memory through a combinational read port.

Pointer modes can chain. Bit 15 of each fetched word means "this is another pointer". The lower 15 bits of that word then give the next address to read. The walk stops at the first word whose bit 15 is clear, or after a fixed number of reads, which ends the walk with an error. The indexed mode can post-increment its index register. Address arithmetic wraps modulo 2^16. A new request is taken only while no pointer walk is in progress.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (immediate): `result` equals the address field and `res_is_opnd` is 1. There is no memory read.
- R2: Mode code 1 (direct): `result` equals the address field and `res_is_opnd` is 0.
- R3: Mode code 3 (register): `result` equals the contents of the register selected by `reg_sel` and `res_is_opnd` is 1. There is no memory read.
- R4: Mode code 4 (register indirect): `result` equals the contents of register `reg_sel` and `res_is_opnd` is 0.
- R5: Mode code 5 (displacement): `result` equals the address field plus register `reg_sel`, modulo 2^16.
- R6: Mode code 6 (PC-relative): `result` equals `pc` plus the address field, modulo 2^16.
- R7: Mode code 7 (indexed): `result` equals the address field plus register `reg_sel`, modulo 2^16. When `auto_inc` is 1, the old register value plus 1 is written back to that register in the `done` cycle. With `auto_inc` at 0, or in any other mode, nothing is written.
- R8: Mode code 8 (stack top): `result` equals the contents of register 7, the stack pointer, and `res_is_opnd` is 0.
- R9: Mode code 2 (indirect): the first memory read is at the address field. While a fetched word has bit 15 set, the next read is at that word's bits 14:0. `result` is the first word read with bit 15 clear. `done` arrives 1 + (number of reads) cycles after `start` is sampled.
- R10: If the fourth read in an indirect walk still has bit 15 set, the walk ends with `err` = 1 and `result` equal to that fourth word, 5 cycles after `start`.
- R11: Every mode except indirect pulses `done` for exactly one cycle, 1 cycle after `start` is sampled. For legal modes `err` is 0 and no memory read is made.
- R12: While `busy` is high, `start` is ignored. The walk in progress is not disturbed, and the ignored request produces no extra `done`.
- R13: Mode codes 9 to 15 complete in 1 cycle with `err` = 1 and `result` = 0. They make no memory read and no register write.
- R14: During and right after reset, `done`, `err`, `busy`, `mem_rd_en` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled when not busy |
| mode | input | 4 | Addressing mode code |
| addr_fld | input | 16 | Address field of the instruction |
| reg_sel | input | 3 | Register selector |
| auto_inc | input | 1 | Post-increment request for indexed mode |
| pc | input | 16 | Current program counter |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 3 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, valid in the same cycle |
| busy | output | 1 | Pointer walk in progress |
| done | output | 1 | Result valid for one cycle |
| result | output | 16 | Effective address or operand value |
| res_is_opnd | output | 1 | Result is the operand itself |
| err | output | 1 | Walk too deep or illegal mode |

## Verification
A wrong mode decode or a wrong arithmetic path shows up at `result` in the `done` cycle, one cycle after the request. A stuck or miscounted level counter in the pointer walk shows in several ways: the wrong number of `mem_rd_en` cycles, a `done` that comes early or late, or an `err` on the wrong depth. All of these appear within five cycles of `start`. A lost busy state lets a second request start during a walk, which shows as an extra `done` or a corrupted result. A broken write-back path shows as a wrong register value on the very next request that reads that register.

// File: rtl/eag_pkg.sv
// Shared mode encoding for the effective address generator.
// Assumes a 4-bit mode field; codes above AM_STK are illegal.
package eag_pkg;
    typedef enum logic [3:0] {
        AM_IMM  = 4'd0,
        AM_DIR  = 4'd1,
        AM_IND  = 4'd2,
        AM_REG  = 4'd3,
        AM_RIND = 4'd4,
        AM_DISP = 4'd5,
        AM_REL  = 4'd6,
        AM_IDX  = 4'd7,
        AM_STK  = 4'd8
    } am_e;

    localparam int MODE_W = 4;
endpackage

// File: rtl/eag_addr_calc.sv
// Combinational single-pass address former.
// Does: decodes the mode and forms the effective address or operand for
// every mode that needs no memory read.
// Assumes: regv already holds the register chosen for this mode (the stack
// pointer for stack mode). Sums wrap at AW bits.
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     afld,
    input  logic [AW-1:0]     regv,
    input  logic [AW-1:0]     pcv,
    input  logic              inc_req,
    output logic [AW-1:0]     ea,
    output logic              is_opnd,
    output logic              needs_walk,
    output logic              illegal,
    output logic              wants_inc
);
    // decode the mode and pick the address arithmetic
    always_comb begin
        ea         = '0;
        is_opnd    = 1'b0;
        needs_walk = 1'b0;
        illegal    = 1'b0;
        wants_inc  = 1'b0;
        case (mode)
            AM_IMM: begin
                ea      = afld;
                is_opnd = 1'b1;
            end
            AM_DIR:  ea = afld;
            AM_IND: begin
                ea         = afld;
                needs_walk = 1'b1;
            end
            AM_REG: begin
                ea      = regv;
                is_opnd = 1'b1;
            end
            AM_RIND: ea = regv;
            AM_DISP: ea = afld + regv;
            AM_REL:  ea = pcv + afld;
            AM_IDX: begin
                ea        = afld + regv;
                wants_inc = inc_req;
            end
            AM_STK:  ea = regv;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/eag_ptr_walk.sv
// Pointer chain walker.
// Does: reads memory at the launch address; while the fetched word's top
// bit is set, follows its lower bits to the next read. Ends on a clear top
// bit or after MAX_LVL reads, which is an error.
// Assumes: the memory read data is valid in the same cycle as the address.
module eag_ptr_walk #(
    parameter int AW      = 16,
    parameter int MAX_LVL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] base,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [AW-1:0] mem_rd_data,
    output logic          busy,
    output logic          fin,
    output logic [AW-1:0] fin_word,
    output logic          fin_err
);
    localparam int LW = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1;
    localparam logic [LW-1:0] LAST_LVL = LW'(MAX_LVL - 1);

    logic          active;
    logic [AW-1:0] ptr;
    logic [LW-1:0] lvl;
    logic          chain;
    logic          at_limit;

    // classify the word fetched this cycle
    always_comb begin
        chain     = mem_rd_data[AW-1];
        at_limit  = (lvl == LAST_LVL);
        mem_rd_en = active;
        mem_rd_addr = ptr;
        busy      = active;
        fin       = active && (!chain || at_limit);
        fin_err   = active && chain && at_limit;
        fin_word  = mem_rd_data;
    end

    // advance the walk one level per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ptr    <= '0;
            lvl    <= '0;
        end else if (active) begin
            if (!chain || at_limit) begin
                active <= 1'b0;
            end else begin
                ptr <= {1'b0, mem_rd_data[AW-2:0]};
                lvl <= lvl + LW'(1);
            end
        end else if (launch) begin
            active <= 1'b1;
            ptr    <= base;
            lvl    <= '0;
        end
    end
endmodule

// File: rtl/eag_unit.sv
// Effective address generator top.
// Does: accepts a request when idle. Resolves register and arithmetic modes
// in one cycle and hands indirect modes to the pointer walker. Registers the
// result with a one-cycle done pulse and post-increments the index register
// when asked.
// Assumes: combinational register-file and memory read ports; the register
// file applies a write on the clock edge that ends the done cycle.
module eag_unit
    import eag_pkg::*;
#(
    parameter int AW      = 16,
    parameter int RSEL_W  = 3,
    parameter int SP_IDX  = 7,
    parameter int MAX_LVL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     addr_fld,
    input  logic [RSEL_W-1:0] reg_sel,
    input  logic              auto_inc,
    input  logic [AW-1:0]     pc,
    output logic [RSEL_W-1:0] rf_rd_idx,
    input  logic [AW-1:0]     rf_rd_data,
    output logic              rf_wr_en,
    output logic [RSEL_W-1:0] rf_wr_idx,
    output logic [AW-1:0]     rf_wr_data,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [AW-1:0]     mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     result,
    output logic              res_is_opnd,
    output logic              err
);
    logic [AW-1:0] ea;
    logic          is_opnd;
    logic          needs_walk;
    logic          illegal;
    logic          wants_inc;
    logic          accept;
    logic          walk_busy;
    logic          walk_fin;
    logic [AW-1:0] walk_word;
    logic          walk_err;

    logic              done_q;
    logic [AW-1:0]     result_q;
    logic              opnd_q;
    logic              err_q;
    logic              wr_en_q;
    logic [RSEL_W-1:0] wr_idx_q;
    logic [AW-1:0]     wr_data_q;

    // choose the register to read: stack pointer for stack mode
    always_comb begin
        if (mode == AM_STK) rf_rd_idx = RSEL_W'(SP_IDX);
        else                rf_rd_idx = reg_sel;
        accept = start && !walk_busy;
    end

    eag_addr_calc #(.AW(AW)) u_calc (
        .mode       (mode),
        .afld       (addr_fld),
        .regv       (rf_rd_data),
        .pcv        (pc),
        .inc_req    (auto_inc),
        .ea         (ea),
        .is_opnd    (is_opnd),
        .needs_walk (needs_walk),
        .illegal    (illegal),
        .wants_inc  (wants_inc)
    );

    eag_ptr_walk #(.AW(AW), .MAX_LVL(MAX_LVL)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (accept && needs_walk),
        .base        (addr_fld),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .busy        (walk_busy),
        .fin         (walk_fin),
        .fin_word    (walk_word),
        .fin_err     (walk_err)
    );

    // register the result, the done pulse and the write-back request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            result_q  <= '0;
            opnd_q    <= 1'b0;
            err_q     <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            wr_en_q <= 1'b0;
            if (walk_fin) begin
                done_q   <= 1'b1;
                result_q <= walk_word;
                opnd_q   <= 1'b0;
                err_q    <= walk_err;
            end else if (accept && !needs_walk) begin
                done_q    <= 1'b1;
                result_q  <= ea;
                opnd_q    <= is_opnd;
                err_q     <= illegal;
                wr_en_q   <= wants_inc;
                wr_idx_q  <= reg_sel;
                wr_data_q <= rf_rd_data + AW'(1);
            end
        end
    end

    // drive the outputs from the registered state
    always_comb begin
        busy        = walk_busy;
        done        = done_q;
        result      = result_q;
        res_is_opnd = opnd_q;
        err         = err_q;
        rf_wr_en    = wr_en_q;
        rf_wr_idx   = wr_idx_q;
        rf_wr_data  = wr_data_q;
    end
endmodule

// File: rtl/eag_unit_chk.sv
// Property checker for eag_unit, attached with bind.
// Does: checks the timing relations between done, err, busy, the memory
// read port and the write port.
// Assumes: synchronous active-low reset, held low from time zero.
module eag_unit_chk #(
    parameter int AW      = 16,
    parameter int MAX_LVL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          busy,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_rd_addr,
    input logic          rf_wr_en
);
    int run;

    // count back-to-back read cycles of one walk
    always_ff @(posedge clk) begin
        if (!rst_n)         run <= 0;
        else if (mem_rd_en) run <= run + 1;
        else                run <= 0;
    end

    assert_walk_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (run < MAX_LVL));

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    assert_wr_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);

    assert_read_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_chain_addr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> !mem_rd_addr[AW-1]);

    assert_reset_quiet_R14: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && !busy && !mem_rd_en && !rf_wr_en));
endmodule

bind eag_unit eag_unit_chk #(.AW(AW), .MAX_LVL(MAX_LVL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .err         (err),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .rf_wr_en    (rf_wr_en)
);

// File: tb/tb_eag_unit.sv
module tb_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [15:0] a_i = '0;
    logic [2:0]  r_i = '0;
    logic        ai_i = 1'b0;
    logic [15:0] pc_i = '0;

    logic [2:0]  rf_rd_idx;
    logic [15:0] rf_rd_data;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_idx;
    logic [15:0] rf_wr_data;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [15:0] mem_rd_data;
    logic        busy, done, res_is_opnd, err;
    logic [15:0] result;

    logic [15:0] rf [8];
    int checks = 0;
    int errors = 0;
    int nreads = 0;

    always #10 clk = ~clk;

    eag_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i),
        .addr_fld(a_i), .reg_sel(r_i), .auto_inc(ai_i), .pc(pc_i),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .result(result), .res_is_opnd(res_is_opnd),
        .err(err)
    );

    // memory model: low 3 address bits nonzero -> pointer to address-1
    function automatic logic [15:0] mem_word(input logic [15:0] ad);
        if (ad[2:0] != 3'd0) return {1'b1, ad[14:0] - 15'd1};
        return {1'b0, ad[14:0] ^ 15'h2A5A};
    endfunction

    assign mem_rd_data = mem_word(mem_rd_addr);
    assign rf_rd_data  = rf[rf_rd_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) rf[i] <= 16'(16'hFFF0 + i * 16'h2345);
        end else if (rf_wr_en) begin
            rf[rf_wr_idx] <= rf_wr_data;
        end
        if (rst_n && mem_rd_en) nreads <= nreads + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R9";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R13";
        endcase
    endfunction

    task automatic expect_op(input logic [3:0] m, input logic [15:0] a,
                             input logic [2:0] r, input logic [15:0] pcv,
                             output logic [15:0] res, output logic opnd,
                             output logic e, output int lat, output int rd);
        int n;
        res = 16'h0; opnd = 1'b0; e = 1'b0; lat = 1; rd = 0;
        case (m)
            4'd0: begin res = a; opnd = 1'b1; end
            4'd1: res = a;
            4'd2: begin
                n = int'(a[2:0]) + 1;
                if (n <= 4) begin
                    rd  = n;
                    res = {1'b0, (a[14:0] - 15'(a[2:0])) ^ 15'h2A5A};
                end else begin
                    rd  = 4;
                    e   = 1'b1;
                    res = {1'b1, a[14:0] - 15'd4};
                end
                lat = rd + 1;
            end
            4'd3: begin res = rf[r]; opnd = 1'b1; end
            4'd4: res = rf[r];
            4'd5, 4'd7: res = a + rf[r];
            4'd6: res = pcv + a;
            4'd8: res = rf[7];
            default: e = 1'b1;
        endcase
    endtask

    task automatic run_op(input logic [3:0] m, input logic [15:0] a,
                          input logic [2:0] r, input logic ai,
                          input logic [15:0] pcv, input bit junk);
        logic [15:0] eres, old;
        logic eopnd, eerr;
        int elat, erd, lat, base;
        string rq;
        rq = req_of(m);
        expect_op(m, a, r, pcv, eres, eopnd, eerr, elat, erd);
        old  = rf[r];
        base = nreads;
        @(negedge clk);
        start = 1'b1; mode_i = m; a_i = a; r_i = r; ai_i = ai; pc_i = pcv;
        @(negedge clk);
        lat = 1;
        if (junk && elat > 1) begin
            mode_i = 4'd0; a_i = 16'h1234; ai_i = 1'b1;
        end else begin
            start = 1'b0;
        end
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
            if (!junk || lat >= elat) start = 1'b0;
        end
        start = 1'b0;
        chk(done == 1'b1 && lat == elat, (m == 4'd2) ? "R9" : "R11", "done latency",
            16'(lat), 16'(elat));
        chk(result == eres, (eerr && m == 4'd2) ? "R10" : rq, "result", result, eres);
        chk(res_is_opnd == eopnd, rq, "res_is_opnd", 16'(res_is_opnd), 16'(eopnd));
        chk(err == eerr, (m == 4'd2) ? "R10" : "R11", "err", 16'(err), 16'(eerr));
        chk(nreads - base == erd, (m == 4'd2) ? "R9" : "R11", "memory reads",
            16'(nreads - base), 16'(erd));
        @(negedge clk);
        chk(done == 1'b0, junk ? "R12" : "R11", "done single pulse", 16'(done), 16'h0);
        chk(rf[r] == ((m == 4'd7 && ai) ? old + 16'd1 : old), "R7", "index write-back",
            rf[r], (m == 4'd7 && ai) ? old + 16'd1 : old);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired: actual %h expected %h", 16'h1, 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: quiet outputs while reset is held
        chk(!done && !err && !busy && !mem_rd_en && !rf_wr_en, "R14", "reset outputs",
            {11'd0, done, err, busy, mem_rd_en, rf_wr_en}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mem_rd_en, "R14", "after reset",
            {13'd0, done, busy, mem_rd_en}, 16'h0);

        // near-exhaustive sweep: all mode codes, all registers, both auto bits
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 24; i++) begin
                for (int r = 0; r < 8; r++) begin
                    for (int ai = 0; ai < 2; ai++) begin
                        logic [15:0] a, p;
                        a = 16'(i * 16'h1F3B);
                        if (i[0]) a = ~a;
                        p = 16'(a * 3) ^ 16'hBEEF ^ 16'(r);
                        run_op(4'(m), a, 3'(r), ai[0], p, 1'b0);
                    end
                end
            end
        end

        // R12: start held high with another request during pointer walks
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            a = {16'(i * 16'h0731)} & 16'hFFF8;
            a = a | 16'(1 + (i % 7));
            run_op(4'd2, a, 3'(i), 1'b0, 16'h0100, 1'b1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule